// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block runs on the memory device side of a synchronous DRAM. On every rising clock edge it looks at the clock-enable pin and the command strobes. It compares the clock-enable level with the level it registered at the edge before. From that pair, the command, and two status flags from the bank logic, it decides the device's low-power state. The possible states are normal operation, power-down, self refresh, clock suspend, and the recovery window that follows self refresh.

The tracker reports the state on a small encoded bus. It raises a one-cycle strobe when a real command is taken in normal operation, and it raises a one-cycle flag when the combination seen at an edge is not allowed. After self refresh ends, a down-counter holds the device in recovery for a programmable number of edges. During that window only idle commands are allowed, and a minimum number of them must be true no-operation commands. All outputs are registered, so the outcome of edge n is visible from edge n until edge n+1.

Top module: `sdram_cke_tracker`

## Requirements
- R1: A synchronous active-high reset puts the tracker in normal state (code 0) with both strobes low, and records the previous clock-enable as high. An edge right after reset with clock-enable low, all banks idle and a no-op therefore enters power-down.
- R2: The state codes are: 0 normal, 1 power-down, 2 self refresh, 3 clock suspend, 4 self-refresh recovery. Commands are decoded from {cs_n, ras_n, cas_n, we_n}. cs_n high is inhibit. 0111 is a no-op. 0001 is auto refresh. Any other pattern with cs_n low is a real command.
- R3: In normal state, on an edge where clock-enable goes from high to low with all banks idle, a no-op or inhibit enters power-down and auto refresh enters self refresh.
- R4: In normal state, on a high-to-low clock-enable edge while a burst is active and cs_n is low, the tracker enters clock suspend. The burst condition is checked before the idle-bank condition.
- R5: While clock-enable is low at both the previous and the current edge, power-down, self refresh and clock suspend are kept for any command, with no illegal flag.
- R6: A low-to-high clock-enable edge in power-down with a no-op or inhibit returns to normal at that edge. Any other command there is illegal.
- R7: A low-to-high clock-enable edge in clock suspend returns to normal whatever the command, and the next edge accepts commands again.
- R8: A low-to-high clock-enable edge in self refresh with a no-op or inhibit enters recovery. Recovery lasts TXSR further edges with clock-enable high, and the state returns to normal at the last of them.
- R9: During recovery, a command that is neither no-op nor inhibit, or a low clock-enable, is illegal, and that edge does not advance the window.
- R10: If fewer than MIN_NOPS no-ops (inhibits do not count) arrive in the recovery window, the illegal flag pulses at the edge that closes it. The state still returns to normal.
- R11: Every other illegal edge leaves the state unchanged, and illegal and accept are never high together.
- R12: The accept strobe is high for one cycle exactly when, in normal state with clock-enable high on both edges, a real command (cs_n low, not a no-op) is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | All banks are precharged and idle |
| burst_active | input | 1 | A read or write burst is in progress |
| pwr_state | output | 3 | Current power state code (R2) |
| cmd_accept | output | 1 | One-cycle strobe for an accepted command |
| illegal | output | 1 | One-cycle flag for a disallowed edge |

## Verification
The bench goes after the edges where the previous clock-enable level matters. One is the first edge after reset: a tracker that forgets to preset the old level high flags it as illegal instead of entering power-down. The recovery window is checked at full length, with a bad command in the middle and with too few no-ops. A design that lets the bad edge advance the count returns to normal one edge early, and one that counts inhibits as no-ops misses the closing flag. The bench also checks that a non-idle command on power-down exit leaves the state alone, that burst priority wins when both status flags are set, and that clock suspend exit takes any command.

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker #(
  parameter int TXSR     = 10,
  parameter int MIN_NOPS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  input  logic       burst_active,
  output logic [2:0] pwr_state,
  output logic       cmd_accept,
  output logic       illegal
);
  localparam int CW = $clog2(TXSR + 1);
  localparam int NW = $clog2(MIN_NOPS + 1);

  typedef enum logic [2:0] {
    S_NORM = 3'd0, S_PDN = 3'd1, S_SREF = 3'd2, S_SUSP = 3'd3, S_RECOV = 3'd4
  } pstate_t;

  pstate_t        st_q, st_d;
  logic           cke_q;
  logic [CW-1:0]  win_q, win_d;
  logic [NW-1:0]  nop_q, nop_d, nop_inc;
  logic           acc_d, ill_d;

  wire is_inh  = cs_n;
  wire is_nop  = !cs_n && ras_n && cas_n && we_n;
  wire is_aref = !cs_n && !ras_n && !cas_n && we_n;
  wire quiet   = is_inh || is_nop;
  wire low_pwr = (st_q == S_PDN) || (st_q == S_SREF) || (st_q == S_SUSP);

  assign nop_inc = (is_nop && (nop_q < NW'(MIN_NOPS))) ? nop_q + NW'(1) : nop_q;

  always_comb begin
    st_d  = st_q;
    win_d = win_q;
    nop_d = nop_q;
    acc_d = 1'b0;
    ill_d = 1'b0;
    case ({cke_q, cke})
      2'b00: ill_d = !low_pwr;
      2'b01: begin
        case (st_q)
          S_PDN:  if (quiet) st_d = S_NORM; else ill_d = 1'b1;
          S_SREF: if (quiet) begin
                    st_d  = S_RECOV;
                    win_d = CW'(TXSR);
                    nop_d = '0;
                  end else ill_d = 1'b1;
          S_SUSP: st_d = S_NORM;
          default: ill_d = 1'b1;
        endcase
      end
      2'b10: begin
        if (st_q == S_NORM && burst_active && !cs_n)      st_d = S_SUSP;
        else if (st_q == S_NORM && banks_idle && quiet)   st_d = S_PDN;
        else if (st_q == S_NORM && banks_idle && is_aref) st_d = S_SREF;
        else                                              ill_d = 1'b1;
      end
      default: begin
        case (st_q)
          S_NORM:  acc_d = !cs_n && !is_nop;
          S_RECOV: if (quiet) begin
                     win_d = win_q - CW'(1);
                     nop_d = nop_inc;
                     if (win_q == CW'(1)) begin
                       st_d  = S_NORM;
                       ill_d = nop_inc < NW'(MIN_NOPS);
                     end
                   end else ill_d = 1'b1;
          default: ill_d = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_NORM;
      cke_q      <= 1'b1;
      win_q      <= '0;
      nop_q      <= '0;
      cmd_accept <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      st_q       <= st_d;
      cke_q      <= cke;
      win_q      <= win_d;
      nop_q      <= nop_d;
      cmd_accept <= acc_d;
      illegal    <= ill_d;
    end
  end

  assign pwr_state = st_q;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !cke_q && !cke && low_pwr) |=> ($stable(pwr_state) && !illegal)); // R5
  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (past_ok && illegal) |-> ($stable(pwr_state) ||
      ($past(pwr_state) == 3'd4 && pwr_state == 3'd0))); // R11
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(illegal && cmd_accept)); // R11
  AST_ACCEPT_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cmd_accept) |-> (pwr_state == 3'd0 && $past(pwr_state) == 3'd0)); // R12
  AST_RECOV_FROM_SREF: assert property (@(posedge clk) disable iff (rst)
    (past_ok && pwr_state == 3'd4 && $past(pwr_state) != 3'd4) |-> $past(pwr_state) == 3'd2); // R8
  AST_SUSP_NEEDS_BURST: assert property (@(posedge clk) disable iff (rst)
    (past_ok && pwr_state == 3'd3 && $past(pwr_state) != 3'd3) |-> $past(burst_active)); // R4
endmodule

// File: tb/sdram_cke_tracker_tb_top.sv
module sdram_cke_tracker_tb_top;
  localparam int TXSR = 10;
  localparam logic [3:0] C_INH = 4'b1111, C_NOP = 4'b0111, C_AREF = 4'b0001,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_ACT = 4'b0011;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1, idle = 1'b1, burst = 1'b0;
  logic [3:0] cmd = C_NOP;
  logic [2:0] pwr_state;
  logic cmd_accept, illegal;
  int checks = 0, fails = 0;
  int m_state = 0, m_left = 0, m_nops = 0;
  bit m_prev = 1'b1, m_acc = 1'b0, m_ill = 1'b0;

  always #4 clk = ~clk;

  sdram_cke_tracker #(.TXSR(TXSR), .MIN_NOPS(2)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cmd[3]), .ras_n(cmd[2]),
    .cas_n(cmd[1]), .we_n(cmd[0]), .banks_idle(idle), .burst_active(burst),
    .pwr_state(pwr_state), .cmd_accept(cmd_accept), .illegal(illegal));

  task automatic model_edge();
    bit q = (cmd == C_NOP) || cmd[3];
    bit real_cmd = !cmd[3] && cmd != C_NOP;
    m_acc = 1'b0; m_ill = 1'b0;
    if (!m_prev && !cke) begin
      if (!(m_state >= 1 && m_state <= 3)) m_ill = 1'b1;
    end else if (!m_prev && cke) begin
      if (m_state == 1 && q) m_state = 0;
      else if (m_state == 2 && q) begin m_state = 4; m_left = TXSR; m_nops = 0; end
      else if (m_state == 3) m_state = 0;
      else m_ill = 1'b1;
    end else if (m_prev && !cke) begin
      if (m_state == 0 && burst && !cmd[3]) m_state = 3;
      else if (m_state == 0 && idle && q) m_state = 1;
      else if (m_state == 0 && idle && cmd == C_AREF) m_state = 2;
      else m_ill = 1'b1;
    end else begin
      if (m_state == 0) m_acc = real_cmd;
      else if (m_state == 4 && q) begin
        if (cmd == C_NOP) m_nops++;
        m_left--;
        if (m_left == 0) begin m_state = 0; m_ill = (m_nops < 2); end
      end else m_ill = 1'b1;
    end
    m_prev = cke;
  endtask

  task automatic compare(string req);
    checks++;
    if (pwr_state !== 3'(m_state) || cmd_accept !== m_acc || illegal !== m_ill) begin
      fails++;
      $display("FAIL %s: state/acc/ill actual %0d/%0b/%0b expected %0d/%0b/%0b",
               req, pwr_state, cmd_accept, illegal, m_state, m_acc, m_ill);
    end
  endtask

  task automatic step(input bit c, input logic [3:0] k, input bit id, input bit bu, input string req);
    cke = c; cmd = k; idle = id; burst = bu;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1'b1; cke = 1'b1; cmd = C_NOP;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_state = 0; m_prev = 1'b1; m_acc = 1'b0; m_ill = 1'b0; m_left = 0; m_nops = 0;
    compare("R1 reset");
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(0, C_NOP, 1, 0, "R1 R3 power-down right after reset");
    step(0, C_RD,  1, 0, "R5 hold power-down");
    step(1, C_NOP, 1, 0, "R6 power-down exit");
    step(1, C_RD,  1, 0, "R12 read accepted");
    step(1, C_NOP, 1, 0, "R12 nop not accepted");
    step(1, C_INH, 1, 0, "R12 inhibit not accepted");
    step(1, C_ACT, 0, 0, "R2 R12 activate accepted");
    step(0, C_INH, 1, 0, "R3 inhibit enters power-down");
    step(1, C_RD,  1, 0, "R6 R11 bad power-down exit");
    step(1, C_NOP, 1, 0, "R11 still illegal");
    step(0, C_NOP, 1, 0, "R11 fall in power-down illegal");
    step(0, C_WR,  1, 0, "R5 hold");
    step(1, C_INH, 1, 0, "R6 exit with inhibit");
    step(0, C_AREF, 1, 0, "R3 self refresh entry");
    for (int i = 0; i < 3; i++) step(0, C_ACT, 1, 0, "R5 hold self refresh");
    step(1, C_NOP, 1, 0, "R8 recovery entry");
    for (int i = 0; i < TXSR; i++) step(1, C_NOP, 1, 0, "R8 recovery window");
    step(1, C_WR, 1, 0, "R8 R12 normal after recovery");
    step(0, C_AREF, 1, 0, "R3 self refresh again");
    step(1, C_INH, 1, 0, "R8 exit with inhibit");
    step(1, C_NOP, 1, 0, "R9 window");
    step(1, C_RD,  1, 0, "R9 bad command in window");
    step(0, C_NOP, 1, 0, "R9 low cke in window");
    step(1, C_NOP, 1, 0, "R9 rise in window");
    for (int i = 0; i < TXSR; i++) step(1, C_NOP, 1, 0, "R9 window not advanced");
    step(0, C_AREF, 1, 0, "R3 self refresh third");
    step(1, C_NOP, 1, 0, "R8 exit");
    step(1, C_NOP, 1, 0, "R10 one nop");
    for (int i = 1; i < TXSR; i++) step(1, C_INH, 1, 0, "R10 inhibits do not count");
    step(1, C_RD, 1, 1, "R12 accept before suspend");
    step(0, C_RD, 1, 1, "R4 suspend entry burst priority");
    step(0, C_ACT, 0, 1, "R5 hold suspend");
    step(1, C_WR, 0, 1, "R7 suspend exit any command");
    step(1, C_WR, 0, 1, "R7 next edge accepts");
    step(0, C_INH, 0, 1, "R4 inhibit cannot suspend");
    step(0, C_NOP, 0, 0, "R11 low in normal illegal");
    step(1, C_NOP, 0, 0, "R11 rise in normal illegal");
    step(0, C_RD, 1, 0, "R3 read with idle banks illegal");
    step(1, C_NOP, 1, 0, "R11 recover");
    step(1, C_NOP, 1, 0, "R11 normal");
    step(0, C_AREF, 1, 0, "R3 self refresh fourth");
    step(1, C_WR, 1, 0, "R8 bad self refresh exit");
    step(0, C_NOP, 1, 0, "R11 fall in self refresh illegal");
    step(0, C_NOP, 1, 0, "R5 hold");
    do_reset();
    step(1, C_RD, 1, 0, "R1 R12 accept after reset");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule